// File: doc/BRIEF.md
# Join-Triggered Stallable Pipeline Handler

This block waits on two valid/ready operand channels and starts work only in a cycle when both carry a message. Both operands are taken together. The first stage adds them and bumps a shared 19-bit counter. The second stage looks at the sign of the registered sum.

A strictly positive sum is offered at once on a result channel with backpressure. Any other sum is complemented into a second register. While that happens, a one-cycle notify pulse goes out with no acknowledge. The complement is offered on the result channel in the next cycle.

A fresh operand pair may enter in every cycle, so several pairs can be in flight at once. A result that is blocked by the receiver holds its stage. That stall works back toward the inputs, so no result is ever lost. The shared counter can be read at any time on an output port.

Top module: `jp_handler`

## Requirements
- R1: A pair is taken only in a cycle where `a_valid` and `b_valid` are both high. `a_ready` and `b_ready` are never high unless both valids are high. With only one side valid, nothing is taken and `count` does not move.
- R2: For a positive sum, `res_data` equals `a_data + b_data` modulo 2^DATA_W. With `res_ready` high, it is offered in the cycle right after the pair is taken.
- R3: `count` is CNT_W (19) bits wide and reads 5 after reset. It rises by exactly one for each pair taken, wraps modulo 2^CNT_W, and holds in every other cycle, stalls included.
- R4: A sum is positive when its top bit is 0 and it is not zero. A zero sum, or a sum with the top bit set, takes the complement path. This includes a sum that overflowed into the top bit.
- R5: On the complement path, `note_valid` is high for one cycle as the sum leaves stage one. In the next cycle, `res_valid` is high with `res_data` equal to the bitwise NOT of the sum. There is exactly one notify pulse per complement-path pair.
- R6: The notify output has no acknowledge and never stalls the handler. A stream of complement-path pairs with `res_ready` high is taken one per cycle.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays stable. Every result is delivered once, in the order the pairs were taken.
- R8: With `res_ready` high and positive sums, a new pair is taken in every cycle.
- R9: When stage one holds an item that cannot move because the result channel is blocked, `a_ready` and `b_ready` are low. The held item is kept unchanged.
- R10: After a synchronous reset, with `rst_n` low at a clock edge, `res_valid` and `note_valid` are low and `count` reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Operand A present |
| a_data | input | DATA_W | Operand A |
| a_ready | output | 1 | Operand A taken this cycle (together with B) |
| b_valid | input | 1 | Operand B present |
| b_data | input | DATA_W | Operand B |
| b_ready | output | 1 | Operand B taken this cycle (together with A) |
| res_valid | output | 1 | Result offered |
| res_data | output | DATA_W | Sum or complemented sum |
| res_ready | input | 1 | Receiver accepts the result |
| note_valid | output | 1 | Fire-and-forget notify pulse |
| count | output | CNT_W | Shared counter of pairs taken |

## Verification
A pair counts as taken at the clock edge where both readies are sampled high. Timing after that edge is fixed:
- The counter shows the increment right after that edge.
- A positive sum is on the result port one cycle later.
- On the complement path, the notify pulse comes one cycle after the edge and the complement one cycle after that.

The bench drives its inputs on the falling edge and samples just before the next rising edge. It checks these exact cycles on isolated pairs. Under a throttled `res_ready`, a queue of expected results, filled at the edge that takes each pair, is matched against every result handshake in order.

// File: rtl/jp_pkg.sv
package jp_pkg;
   // Selects how stage two decides which path a sum takes.
   typedef enum logic {
      CMP_SIGNED   = 1'b0,
      CMP_UNSIGNED = 1'b1
   } cmp_mode_e;
endpackage

// File: rtl/jp_join.sv
module jp_join (
   input  logic a_valid,
   input  logic b_valid,
   input  logic take,
   output logic a_ready,
   output logic b_ready,
   output logic fire
);
   logic both;
   assign both    = a_valid & b_valid;
   assign fire    = both & take;
   assign a_ready = fire;
   assign b_ready = fire;
endmodule

// File: rtl/jp_counter.sv
module jp_counter #(
   parameter int unsigned CNT_W    = 19,
   parameter int unsigned CNT_INIT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   value <= INIT_V;
      else if (inc) value <= value + ONE_V;
   end
endmodule

// File: rtl/jp_stage_sum.sv
module jp_stage_sum #(
   parameter int unsigned       DATA_W   = 16,
   parameter jp_pkg::cmp_mode_e CMP_MODE = jp_pkg::CMP_SIGNED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              go,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic              valid,
   output logic [DATA_W-1:0] sum,
   output logic              pos
);
   localparam int unsigned MSB = DATA_W - 1;

   always_ff @(posedge clk) begin
      if (!rst_n)           valid <= 1'b0;
      else if (!valid || go) valid <= fire;
   end

   always_ff @(posedge clk) begin
      if (fire) sum <= a_in + b_in;
   end

   generate
      if (CMP_MODE == jp_pkg::CMP_SIGNED) begin : g_signed
         assign pos = ~sum[MSB] & (|sum);
      end else begin : g_unsigned
         assign pos = |sum;
      end
   endgenerate
endmodule

// File: rtl/jp_stage_branch.sv
module jp_stage_branch #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] sum_in,
   input  logic              out_ready,
   output logic              valid,
   output logic [DATA_W-1:0] comp,
   output logic              free
);
   assign free = ~valid | out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)         valid <= 1'b0;
      else if (load)      valid <= 1'b1;
      else if (out_ready) valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load) comp <= ~sum_in;
   end
endmodule

// File: rtl/jp_handler.sv
module jp_handler #(
   parameter int unsigned       DATA_W   = 16,
   parameter int unsigned       CNT_W    = 19,
   parameter int unsigned       CNT_INIT = 5,
   parameter jp_pkg::cmp_mode_e CMP_MODE = jp_pkg::CMP_SIGNED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_valid,
   input  logic [DATA_W-1:0] a_data,
   output logic              a_ready,
   input  logic              b_valid,
   input  logic [DATA_W-1:0] b_data,
   output logic              b_ready,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   input  logic              res_ready,
   output logic              note_valid,
   output logic [CNT_W-1:0]  count
);
   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("jp_handler: DATA_W must be at least 2");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cw
         $error("jp_handler: CNT_W must lie in 1..31");
      end
      if (CNT_INIT >= (32'd1 << CNT_W)) begin : g_bad_init
         $error("jp_handler: CNT_INIT does not fit in CNT_W bits");
      end
   endgenerate

   logic              fire, take;
   logic              stg1_valid, stg1_pos, stg1_go;
   logic [DATA_W-1:0] stg1_sum;
   logic              stg2_valid, stg2_free, stg2_load;
   logic [DATA_W-1:0] stg2_comp;

   jp_join u_join (
      .a_valid (a_valid),
      .b_valid (b_valid),
      .take    (take),
      .a_ready (a_ready),
      .b_ready (b_ready),
      .fire    (fire)
   );

   jp_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fire),
      .value (count)
   );

   jp_stage_sum #(.DATA_W(DATA_W), .CMP_MODE(CMP_MODE)) u_s1 (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .go    (stg1_go),
      .a_in  (a_data),
      .b_in  (b_data),
      .valid (stg1_valid),
      .sum   (stg1_sum),
      .pos   (stg1_pos)
   );

   jp_stage_branch #(.DATA_W(DATA_W)) u_s2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (stg2_load),
      .sum_in    (stg1_sum),
      .out_ready (res_ready),
      .valid     (stg2_valid),
      .comp      (stg2_comp),
      .free      (stg2_free)
   );

   // Stage two holds the older item, so it owns the result channel first.
   always_comb begin
      stg2_load = stg1_valid & ~stg1_pos & stg2_free;
      if (stg1_pos) stg1_go = stg1_valid & ~stg2_valid & res_ready;
      else          stg1_go = stg2_load;
      take       = ~stg1_valid | stg1_go;
      note_valid = stg2_load;
      res_valid  = stg2_valid | (stg1_valid & stg1_pos);
      res_data   = stg2_valid ? stg2_comp : stg1_sum;
   end
endmodule

// File: rtl/jp_handler_chk.sv
module jp_handler_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_valid,
   input logic              a_ready,
   input logic              b_valid,
   input logic              b_ready,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              res_ready,
   input logic              note_valid,
   input logic [CNT_W-1:0]  count,
   input logic              stg1_valid
);
   logic taken;
   assign taken = a_valid & a_ready & b_valid & b_ready;

   p_join_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ready || b_ready) |-> (a_valid && b_valid && a_ready && b_ready));

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> count == $past(count) + 1'b1);

   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> $stable(count));

   p_note_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      note_valid |=> res_valid);

   p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

   p_stall_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stg1_valid && res_valid && !res_ready && !note_valid) |-> (!a_ready && !b_ready));
endmodule

bind jp_handler jp_handler_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_valid    (a_valid),
   .a_ready    (a_ready),
   .b_valid    (b_valid),
   .b_ready    (b_ready),
   .res_valid  (res_valid),
   .res_data   (res_data),
   .res_ready  (res_ready),
   .note_valid (note_valid),
   .count      (count),
   .stg1_valid (stg1_valid)
);

// File: tb/tb_jp_handler.sv
`timescale 1ns/1ps
module tb_jp_handler;
   localparam int DW = 16;
   localparam int CW = 19;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          a_valid, b_valid, a_ready, b_ready;
   logic [DW-1:0] a_data, b_data, res_data;
   logic          res_valid, res_ready, note_valid;
   logic [CW-1:0] count;

   jp_handler dut (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
      .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
      .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
      .note_valid(note_valid), .count(count)
   );

   int checks = 0, errors = 0;
   int notes_exp = 0, notes_seen = 0, accepted = 0;
   int rdy_mode = 0, cyc = 0;
   bit done = 0;
   logic [DW-1:0] expq[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Scoreboard push: expected result computed from the requirements.
   task automatic push_exp(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] s;
      s = a + b;
      if (!s[DW-1] && s != '0) expq.push_back(s);
      else begin
         expq.push_back(~s);
         notes_exp++;
      end
      accepted++;
   endtask

   // Called at a falling edge; returns at the falling edge after the taking edge.
   task automatic send(input logic [DW-1:0] a, input logic [DW-1:0] b, output int waits);
      a_data = a; b_data = b; a_valid = 1'b1; b_valid = 1'b1; waits = 0;
      forever begin
         #2;
         if (a_ready && b_ready) break;
         waits++;
         @(negedge clk);
      end
      push_exp(a, b);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      cyc++;
      case (rdy_mode)
         0: res_ready = 1'b1;
         1: res_ready = (cyc % 3) != 0;
         default: res_ready = 1'b0;
      endcase
   end

   // Monitor: samples just before the rising edge.
   always @(negedge clk) begin
      logic [DW-1:0] e;
      #2;
      if (rst_n) begin
         if (note_valid) notes_seen++;
         if (res_valid && res_ready) begin
            if (expq.size() == 0) chk(1'b0, "R7", "result with empty queue", res_data, 0);
            else begin
               e = expq.pop_front();
               chk(res_data == e, "R7", "result order/value", res_data, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int w;
      int lim;
      rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; a_data = '0; b_data = '0;
      res_ready = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      chk(count == 5, "R10", "count in reset", count, 5);
      chk(!res_valid && !note_valid, "R10", "outputs idle in reset", {res_valid, note_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk(count == 5, "R3", "count after reset", count, 5);
      @(negedge clk);

      // R1: one-sided offers are not taken
      a_valid = 1'b1; a_data = 16'd7;
      repeat (4) begin
         #2;
         chk(!a_ready && !b_ready, "R1", "ready with only A", {a_ready, b_ready}, 0);
         @(negedge clk);
      end
      a_valid = 1'b0; b_valid = 1'b1; b_data = 16'd9;
      repeat (4) begin
         #2;
         chk(!a_ready && !b_ready, "R1", "ready with only B", {a_ready, b_ready}, 0);
         @(negedge clk);
      end
      b_valid = 1'b0;
      #2;
      chk(count == 5, "R1", "count after one-sided offers", count, 5);
      @(negedge clk);

      // R8: back-to-back positive pairs
      for (int i = 0; i < 8; i++) begin
         send(DW'(i + 1), DW'(2 * i + 3), w);
         chk(w == 0, "R8", "wait cycles on positive stream", w, 0);
      end
      #2;
      chk(count == CW'(5 + accepted), "R3", "count after stream", count, 5 + accepted);
      @(negedge clk);
      repeat (3) @(negedge clk);

      // R2: positive latency
      send(16'd100, 16'd23, w);
      #2;
      chk(res_valid && res_data == 16'd123, "R2", "positive sum one cycle later", res_data, 123);
      chk(!note_valid, "R4", "no notify for positive sum", note_valid, 0);
      @(negedge clk);
      repeat (3) @(negedge clk);

      // R5: negative sum
      send(16'hFFFB, 16'd2, w);
      #2;
      chk(note_valid && !res_valid, "R5", "notify before complement", {note_valid, res_valid}, 2);
      @(negedge clk); #2;
      chk(res_valid && res_data == 16'h0002, "R5", "complement follows notify", res_data, 2);
      chk(!note_valid, "R5", "single notify pulse", note_valid, 0);
      @(negedge clk);
      repeat (3) @(negedge clk);

      // R4: zero sum and overflow into top bit
      send(16'd0, 16'd0, w);
      #2;
      chk(note_valid && !res_valid, "R4", "zero sum takes complement path", {note_valid, res_valid}, 2);
      @(negedge clk); #2;
      chk(res_valid && res_data == 16'hFFFF, "R4", "complement of zero", res_data, 16'hFFFF);
      @(negedge clk);
      repeat (3) @(negedge clk);
      send(16'h7FFF, 16'd1, w);
      #2;
      chk(note_valid, "R4", "overflowed sum takes complement path", note_valid, 1);
      @(negedge clk); #2;
      chk(res_valid && res_data == 16'h7FFF, "R4", "complement of overflow", res_data, 16'h7FFF);
      @(negedge clk);
      repeat (3) @(negedge clk);

      // R6: complement-path stream never waits on notify
      for (int i = 0; i < 6; i++) begin
         send(16'hFF00, DW'(i), w);
         chk(w == 0, "R6", "wait cycles on complement stream", w, 0);
      end
      repeat (4) @(negedge clk);

      // R9: stall propagation
      rdy_mode = 2;
      repeat (2) @(negedge clk);
      send(16'd5, 16'd6, w);
      a_data = 16'd1; b_data = 16'd1; a_valid = 1'b1; b_valid = 1'b1;
      repeat (5) begin
         #2;
         chk(!a_ready && !b_ready, "R9", "inputs blocked during stall", {a_ready, b_ready}, 0);
         chk(res_valid && res_data == 16'd11, "R7", "held result", res_data, 11);
         @(negedge clk);
      end
      #2;
      chk(count == CW'(5 + accepted), "R9", "no count change during stall", count, 5 + accepted);
      @(negedge clk);
      rdy_mode = 0;
      forever begin
         #2;
         if (a_ready && b_ready) break;
         @(negedge clk);
      end
      push_exp(16'd1, 16'd1);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;

      // R7: mixed values under throttled result channel
      rdy_mode = 1;
      for (int i = 0; i < 40; i++) begin
         send(DW'($urandom), DW'($urandom), w);
      end

      rdy_mode = 0;
      lim = 0;
      while (expq.size() != 0 && lim < 200) begin
         @(negedge clk);
         lim++;
      end
      repeat (2) @(negedge clk);
      #2;
      chk(expq.size() == 0, "R7", "all results delivered", expq.size(), 0);
      chk(notes_seen == notes_exp, "R5", "notify pulse count", notes_seen, notes_exp);
      chk(count == CW'(5 + accepted), "R3", "final count", count, 5 + accepted);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule